// File: doc/BRIEF.md
# Two-Line Interrupt Steering and Handler-Address Multiplexer

This block gathers a set of level-sensitive interrupt sources and steers each one onto one of two request lines toward the processor core: a fast line and a normal line. The fast line has precedence at the core. Software sets up each source through a small register bus. It chooses whether the source is enabled, which line it drives, and its priority. It also stores the address of the handler for that source.

Fast-routed sources are simply ORed together onto the fast line. Normal-routed sources are arbitrated. The pending, enabled source with the largest priority value wins, and the handler address stored for it is placed on an output and in a readable vector register. The core reads the vector register to learn where to jump, and that read marks the winner as in service. While a source is in service the normal line stays low, because nesting is not supported. A write to the end-of-service register reopens arbitration.

If the vector register is read while no source wins, a programmable default address is returned. Sources at or above the implemented count are tied off permanently.

Top module: `irq_two_line_mux`

## Requirements
- R1: After a synchronous active-low reset the following all hold:
  - every source is disabled, routed normal, with priority 0 and handler address 0;
  - the default address is 0;
  - no source is in service;
  - `fast_req` and `norm_req` are low.
- R2: `fast_req` is high in the same cycle that any implemented source is asserted, enabled and routed fast (route bit = 1). This holds whether or not a source is in service.
- R3: `norm_req` is high in the same cycle that any implemented source is asserted, enabled and routed normal, provided no source is in service.
- R4: A source whose enable bit (bit 0 of its configuration word) is 0 has no effect on either request line or on `handler_addr`.
- R5: Among the candidates for the normal line, the source with the largest 4-bit priority (bits 11:8 of its configuration word) wins, and ties go to the lowest index. While `norm_req` is high, `handler_addr` shows the winner's stored handler address.
- R6: A read of the vector register (address 0x02) returns `handler_addr` in the same cycle. If a winner exists and no source is in service, the read puts that winner in service from the next cycle on.
- R7: While a source is in service, `norm_req` stays low and `handler_addr` shows the default address, even when a candidate of higher priority appears.
- R8: A write to the end-of-service register (address 0x03) clears the in-service state from the next cycle on.
- R9: A vector read when no source wins returns the default address (register 0x00, read/write) and does not set the in-service state.
- R10: For a source index at or above the implemented count, the following all hold:
  - its configuration and handler-address writes are ignored;
  - it reads back 0;
  - it never raises a request.
- R11: Configuration words live at 0x40+i and read back as {priority at 11:8, route at 1, enable at 0}. Handler addresses live at 0x80+i and read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Level interrupt inputs, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a vector read acknowledges) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | ADDR_W | Write data |
| bus_rdata | output | ADDR_W | Read data, combinational from the address |
| fast_req | output | 1 | Fast request line to the core |
| norm_req | output | 1 | Normal request line to the core |
| handler_addr | output | ADDR_W | Winner's handler address, or the default address |

## Verification
A wrong in-service flag shows at once on the ports. A flag stuck set keeps `norm_req` low and `handler_addr` at the default in the very next cycle after the acknowledge or end-of-service. A flag stuck clear lets `norm_req` rise again in the cycle after the vector read.

A wrong priority compare or a wrong tie rule shows as a wrong `handler_addr` in the same cycle as the inputs that cause it. A corrupted configuration word shows on the readback and on the request lines combinationally.

The bench compares every output on every cycle against a behavioural model. A fault therefore surfaces in the first cycle in which it has any visible effect.

// File: rtl/irq_mux_pkg.sv
// Package: register addresses and configuration field positions shared by
// the interrupt multiplexer modules. Assumes an 8-bit register address.
package irq_mux_pkg;
    localparam logic [7:0] A_DEFAULT = 8'h00;  // default handler address
    localparam logic [7:0] A_VECTOR  = 8'h02;  // winner address, read acks
    localparam logic [7:0] A_EOS     = 8'h03;  // end-of-service, write only
    localparam logic [7:0] A_CFG     = 8'h40;  // per-source configuration
    localparam logic [7:0] A_HADDR   = 8'h80;  // per-source handler address
    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_ROUTE_BIT = 1;
    localparam int CFG_PRIO_LSB  = 8;
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: per-source configuration store and read-back mux.
// Holds enable, route, priority and handler address for each implemented
// source, plus the default address. Sources at or above NUM_IMPL are tied
// to zero. Assumes NUM_SRC <= 64 so both windows fit the 8-bit address.
module irq_cfg_regs
    import irq_mux_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_IMPL = 6,
    parameter int PRIO_W   = 4,
    parameter int ADDR_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_addr,
    input  logic [ADDR_W-1:0]          bus_wdata,
    output logic [NUM_SRC-1:0]         en_vec,
    output logic [NUM_SRC-1:0]         fast_vec,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    output logic [NUM_SRC*ADDR_W-1:0]  haddr_flat,
    output logic [ADDR_W-1:0]          dflt_addr,
    output logic [ADDR_W-1:0]          cfg_rdata
);
    localparam int PRIO_MSB = CFG_PRIO_LSB + PRIO_W - 1;

    // Default handler address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dflt_addr <= '0;
        else if (bus_wr && bus_addr == A_DEFAULT)
            dflt_addr <= bus_wdata;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g < NUM_IMPL) begin : g_impl
            // Configuration word and handler address for one source.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_vec[g]                     <= 1'b0;
                    fast_vec[g]                   <= 1'b0;
                    prio_flat[g*PRIO_W +: PRIO_W] <= '0;
                    haddr_flat[g*ADDR_W +: ADDR_W] <= '0;
                end else if (bus_wr) begin
                    if (bus_addr == (A_CFG + 8'(g))) begin
                        en_vec[g]                     <= bus_wdata[CFG_EN_BIT];
                        fast_vec[g]                   <= bus_wdata[CFG_ROUTE_BIT];
                        prio_flat[g*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_MSB:CFG_PRIO_LSB];
                    end
                    if (bus_addr == (A_HADDR + 8'(g)))
                        haddr_flat[g*ADDR_W +: ADDR_W] <= bus_wdata;
                end
            end
        end else begin : g_tied
            // Unimplemented source: permanently disabled.
            assign en_vec[g]                      = 1'b0;
            assign fast_vec[g]                    = 1'b0;
            assign prio_flat[g*PRIO_W +: PRIO_W]  = '0;
            assign haddr_flat[g*ADDR_W +: ADDR_W] = '0;
        end
    end

    // Read-back mux for the default, configuration and handler windows.
    always_comb begin
        cfg_rdata = '0;
        if (bus_addr == A_DEFAULT)
            cfg_rdata = dflt_addr;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == (A_CFG + 8'(i))) begin
                cfg_rdata[CFG_EN_BIT]                = en_vec[i];
                cfg_rdata[CFG_ROUTE_BIT]             = fast_vec[i];
                cfg_rdata[PRIO_MSB:CFG_PRIO_LSB]     = prio_flat[i*PRIO_W +: PRIO_W];
            end
            if (bus_addr == (A_HADDR + 8'(i)))
                cfg_rdata = haddr_flat[i*ADDR_W +: ADDR_W];
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
// Module: priority arbiter for normal-line candidates.
// Picks the candidate with the largest priority value; on a tie the
// lowest index wins because only a strictly larger value replaces it.
// Purely combinational; assumes NUM_SRC >= 2.
module irq_prio_arb #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    localparam int IDW    = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      win_valid,
    output logic [IDW-1:0]            win_id
);
    logic [PRIO_W-1:0] best;

    // Linear scan keeping the best priority seen so far.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        best      = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                best      = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R5
    winner_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> cand[win_id]);
endmodule

// File: rtl/irq_service_ctl.sv
// Module: in-service tracker for the normal line.
// Set by an acknowledge (vector read with a winner), cleared by an
// end-of-service write; clearing takes precedence. No nesting.
module irq_service_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic eos,
    output logic busy
);
    // Track whether a normal interrupt is being serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (eos)
            busy <= 1'b0;
        else if (ack)
            busy <= 1'b1;
    end

    // R6
    ack_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !eos |=> busy);
    // R8
    eos_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |=> !busy);
    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !eos |=> busy);
endmodule

// File: rtl/irq_two_line_mux.sv
// Module: top of the two-line interrupt multiplexer.
// Combines the configuration store, the normal-line arbiter and the
// in-service tracker. Requests and handler_addr are combinational from
// src_irq and register state; bus_rdata is combinational from bus_addr.
module irq_two_line_mux
    import irq_mux_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_IMPL = 6,
    parameter int PRIO_W   = 4,
    parameter int ADDR_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [ADDR_W-1:0]  bus_wdata,
    output logic [ADDR_W-1:0]  bus_rdata,
    output logic               fast_req,
    output logic               norm_req,
    output logic [ADDR_W-1:0]  handler_addr
);
    localparam int IDW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        en_vec, fast_vec, cand;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC*ADDR_W-1:0] haddr_flat;
    logic [ADDR_W-1:0]         dflt_addr, cfg_rdata;
    logic                      win_valid, busy, ack, eos;
    logic [IDW-1:0]            win_id;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .NUM_IMPL(NUM_IMPL), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .en_vec(en_vec), .fast_vec(fast_vec),
        .prio_flat(prio_flat), .haddr_flat(haddr_flat),
        .dflt_addr(dflt_addr), .cfg_rdata(cfg_rdata)
    );

    // Normal-line candidates: asserted, enabled, routed normal.
    assign cand = src_irq & en_vec & ~fast_vec;

    irq_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(prio_flat),
        .win_valid(win_valid), .win_id(win_id)
    );

    // Acknowledge on a vector read that finds a presentable winner.
    assign ack = bus_rd && bus_addr == A_VECTOR && win_valid && !busy;
    assign eos = bus_wr && bus_addr == A_EOS;

    irq_service_ctl u_svc (
        .clk(clk), .rst_n(rst_n), .ack(ack), .eos(eos), .busy(busy)
    );

    // Request lines: fast is a plain OR, normal is gated by service.
    assign fast_req = |(src_irq & en_vec & fast_vec);
    assign norm_req = win_valid && !busy;

    // Handler address: winner's entry, else the default for spurious reads.
    always_comb begin
        handler_addr = dflt_addr;
        if (norm_req)
            handler_addr = haddr_flat[win_id*ADDR_W +: ADDR_W];
    end

    // Register read data: vector register or the configuration windows.
    assign bus_rdata = (bus_addr == A_VECTOR) ? handler_addr : cfg_rdata;

    // R6
    no_request_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !eos |=> !norm_req);
endmodule

// File: tb/irq_two_line_mux_test.sv
// Bench: drives inputs on the falling edge, compares every output with a
// behavioural model each cycle, and updates the model on the rising edge.
module irq_two_line_mux_test;
    localparam int NS = 8;
    localparam int NI = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, handler_addr;
    logic        fast_req, norm_req;

    irq_two_line_mux #(.NUM_SRC(NS), .NUM_IMPL(NI), .PRIO_W(4), .ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fast_req(fast_req), .norm_req(norm_req),
        .handler_addr(handler_addr)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    string phase = "R1";

    bit          m_en[NS], m_fast[NS], m_busy;
    int          m_prio[NS];
    logic [31:0] m_ha[NS], m_def;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 0; m_fast[i] = 0; m_prio[i] = 0; m_ha[i] = '0;
        end
        m_def = '0; m_busy = 0;
    endtask

    // One cycle: compare outputs, then apply the edge to the model.
    task automatic tick();
        bit found = 0, fexp = 0, nexp;
        int best = 0, win = 0;
        logic [31:0] hexp, rexp;
        #1;
        for (int i = 0; i < NI; i++) begin
            if (src_irq[i] && m_en[i] && m_fast[i]) fexp = 1;
            if (src_irq[i] && m_en[i] && !m_fast[i] && (!found || m_prio[i] > best)) begin
                found = 1; best = m_prio[i]; win = i;
            end
        end
        nexp = found && !m_busy;
        hexp = nexp ? m_ha[win] : m_def;
        check("fast_req", 32'(fast_req), 32'(fexp));
        check("norm_req", 32'(norm_req), 32'(nexp));
        check("handler_addr", handler_addr, hexp);
        if (bus_rd) begin
            rexp = '0;
            if (bus_addr == 8'h02) rexp = hexp;
            else if (bus_addr == 8'h00) rexp = m_def;
            else if (bus_addr >= 8'h40 && bus_addr < 8'h40 + NI) begin
                rexp[0] = m_en[bus_addr-8'h40];
                rexp[1] = m_fast[bus_addr-8'h40];
                rexp[11:8] = 4'(m_prio[bus_addr-8'h40]);
            end else if (bus_addr >= 8'h80 && bus_addr < 8'h80 + NI)
                rexp = m_ha[bus_addr-8'h80];
            check("bus_rdata", bus_rdata, rexp);
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (bus_rd && bus_addr == 8'h02 && nexp) m_busy = 1;
            if (bus_wr) begin
                if (bus_addr == 8'h00) m_def = bus_wdata;
                if (bus_addr == 8'h03) m_busy = 0;
                if (bus_addr >= 8'h40 && bus_addr < 8'h40 + NI) begin
                    m_en[bus_addr-8'h40] = bus_wdata[0];
                    m_fast[bus_addr-8'h40] = bus_wdata[1];
                    m_prio[bus_addr-8'h40] = int'(bus_wdata[11:8]);
                end
                if (bus_addr >= 8'h80 && bus_addr < 8'h80 + NI)
                    m_ha[bus_addr-8'h80] = bus_wdata;
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a);
        bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        phase = "R1"; tick(); src_irq = 8'hFF; tick(); rd(8'h00); rd(8'h40); rd(8'h02);
        rst_n = 1; src_irq = '0; tick();
        phase = "R11";
        wr(8'h40, 32'h0000_0301); rd(8'h40); rd(8'h41); rd(8'h20);
        for (int i = 0; i < NI; i++) wr(8'(8'h80 + i), 32'h1000 + 32'(i) * 16);
        wr(8'h00, 32'hDEAD_0000); rd(8'h83); rd(8'h00);
        phase = "R4"; src_irq = 8'b0000_0010; tick(); tick();
        phase = "R2"; wr(8'h42, 32'h0000_0F03); src_irq = 8'b0000_0110; tick(); tick();
        phase = "R3"; src_irq = 8'b0000_0001; tick();
        phase = "R5";
        wr(8'h43, 32'h0000_0501); wr(8'h44, 32'h0000_0501);
        src_irq = 8'b0001_1001; tick();
        src_irq = 8'b0001_0001; tick();
        phase = "R6"; src_irq = 8'b0001_1001; rd(8'h02); tick();
        phase = "R7"; wr(8'h45, 32'h0000_0901); src_irq = 8'b0011_1101; tick(); rd(8'h02); tick();
        phase = "R8"; wr(8'h03, 32'h0); tick(); rd(8'h02); tick();
        wr(8'h03, 32'h0); src_irq = 8'b0000_1000; tick();
        phase = "R9"; src_irq = '0; wr(8'h03, 32'h0); rd(8'h02); tick();
        src_irq = 8'b0000_0001; tick();
        phase = "R10";
        src_irq = 8'b1100_0000; wr(8'h46, 32'h0000_0F01); wr(8'h47, 32'h0000_0F03);
        wr(8'h86, 32'h5555_5555); tick(); rd(8'h46); rd(8'h86); rd(8'h02);
        phase = "R4"; wr(8'h40, 32'h0); wr(8'h43, 32'h0); wr(8'h44, 32'h0);
        src_irq = 8'b0001_1001; tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule